// File: doc/BRIEF.md
# Crosstalk Test Pair Sequencer

This block generates the full set of worst-case coupling test patterns for a parallel bus of `WIDTH` lines. One line at a time is the victim, and every other line acts as an aggressor. Each victim gets four fault types: positive glitch, negative glitch, rising delay and falling delay. Every test is delivered as two consecutive words. The first word sets up the bus. The second word carries the transition that excites the coupling fault.

When `BIDIR` is set, each test is issued twice, once per bus direction, and an output flag tells the bus driver which side should drive the word. Words leave through a valid/ready handshake, so a bus-exercising agent downstream can take them at its own pace.

Each word comes with side information: its victim, fault type, test number and phase. This lets the consumer log or compare responses without keeping its own count.

Top module: `crosstalk_pair_gen`

## Requirements
- R1: While reset is held and after reset until `start` is seen, `valid` and `done` are 0.
- R2: A `start` pulse while idle makes the first word valid on the next cycle, with victim 0, fault code 0, `second` = 0, `dir` = 0 and `test_idx` = 0.
- R3: Positive glitch (fault code 0): the first word is all zeros. The second word has the victim bit at 0 and all other bits at 1.
- R4: Negative glitch (fault code 1): the first word is all ones. The second word has the victim bit at 1 and all other bits at 0.
- R5: Rising delay (fault code 2): the first word has the victim at 0 and the others at 1. The second word is its bitwise inverse. With `WIDTH`=8 and victim 7, the words are 01111111 and then 10000000.
- R6: Falling delay (fault code 3): the first word has the victim at 1 and the others at 0. The second word is its bitwise inverse. With `WIDTH`=12 and victim 4, the words are 000000010000 and then 111111101111.
- R7: Order of emission, from innermost to outermost:
  - first word, then second word;
  - direction 0, then direction 1 (only when `BIDIR`=1);
  - fault code 0, 1, 2, 3;
  - victim 0 up to `WIDTH`-1.
  - `test_idx` counts the tests from 0, and each test covers both of its words.
- R8: While `valid` is 1 and `ready` is 0, every output holds its value.
- R9: After the final second word is accepted, `valid` falls and `done` is 1 for exactly one cycle. A run contains 4·`WIDTH`·(1+`BIDIR`) tests, which is 64 for `WIDTH`=8 with `BIDIR`=1.
- R10: A `start` pulse during a run has no effect on the sequence.
- R11: With `BIDIR`=0, `dir` stays 0 and a run contains 4·`WIDTH` tests, which is 48 for `WIDTH`=12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| ready | input | 1 | Consumer accepts the current word |
| valid | output | 1 | A word is being offered |
| vec | output | WIDTH | Bus word |
| second | output | 1 | 0 = first (setup) word, 1 = second (exciting) word |
| test_idx | output | $clog2(4·WIDTH·(1+BIDIR)) | Test number |
| fault | output | 2 | 0 positive glitch, 1 negative glitch, 2 rising delay, 3 falling delay |
| victim | output | $clog2(WIDTH) | Victim line |
| dir | output | 1 | Bus direction for this test |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
The hardest case to reach is the wrap from the last test back to idle when that final word was first held by back-pressure. A stall at that point must neither skip the `done` pulse nor repeat it. The bench deasserts `ready` on a fixed cadence for the whole run, so stalls land on first words, on second words and on direction and victim boundaries. Every offered word is compared with an independently computed pattern, and a stray `start` is injected mid-run. A second instance runs unidirectional at 12 bits to cover the other variant.

// File: rtl/xt_pkg.sv
package xt_pkg;
   typedef enum logic [1:0] {
      FT_GLITCH_POS = 2'd0,
      FT_GLITCH_NEG = 2'd1,
      FT_DELAY_RISE = 2'd2,
      FT_DELAY_FALL = 2'd3
   } fault_e;

   localparam int unsigned NUM_FAULTS = 4;
endpackage

// File: rtl/xt_pattern.sv
module xt_pattern
   import xt_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned VW = $clog2(WIDTH)
) (
   input  logic [VW-1:0]    victim,
   input  fault_e           fault,
   input  logic             second,
   output logic [WIDTH-1:0] vec
);
   logic [WIDTH-1:0] onehot;

   always_comb begin
      onehot = '0;
      onehot[victim] = 1'b1;
   end

   always_comb begin
      unique case (fault)
         FT_GLITCH_POS: vec = second ? ~onehot : '0;
         FT_GLITCH_NEG: vec = second ? onehot : '1;
         FT_DELAY_RISE: vec = second ? onehot : ~onehot;
         default:       vec = second ? ~onehot : onehot;
      endcase
   end
endmodule

// File: rtl/xt_seq.sv
module xt_seq
   import xt_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter bit          BIDIR = 1'b1,
   localparam int unsigned DIRS  = BIDIR ? 2 : 1,
   localparam int unsigned VW    = $clog2(WIDTH),
   localparam int unsigned TW    = $clog2(NUM_FAULTS * WIDTH * DIRS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ready,
   output logic          busy,
   output logic          second,
   output logic          dir,
   output fault_e        fault,
   output logic [VW-1:0] victim,
   output logic [TW-1:0] test_idx,
   output logic          done
);
   logic dir_last;
   logic launch;
   logic step_test;
   logic last_test;

   assign launch    = !busy && start;
   assign last_test = dir_last && (fault == FT_DELAY_FALL)
                    && (victim == VW'(WIDTH - 1));
   assign step_test = busy && ready && second && !last_test;

   generate
      if (BIDIR) begin : g_two_way
         always_ff @(posedge clk) begin
            if (!rst_n || launch) dir <= 1'b0;
            else if (step_test)   dir <= ~dir;
         end
         assign dir_last = dir;
      end else begin : g_one_way
         assign dir      = 1'b0;
         assign dir_last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         second   <= 1'b0;
         fault    <= FT_GLITCH_POS;
         victim   <= '0;
         test_idx <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            busy     <= 1'b1;
            second   <= 1'b0;
            fault    <= FT_GLITCH_POS;
            victim   <= '0;
            test_idx <= '0;
         end else if (busy && ready) begin
            second <= ~second;
            if (second) begin
               if (last_test) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  test_idx <= test_idx + 1'b1;
                  if (dir_last) begin
                     if (fault == FT_DELAY_FALL) begin
                        fault  <= FT_GLITCH_POS;
                        victim <= victim + 1'b1;
                     end else begin
                        fault <= fault_e'(fault + 2'd1);
                     end
                  end
               end
            end
         end
      end
   end

   assert_first_then_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ready && !second) |=> (busy && second));
   assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/crosstalk_pair_gen.sv
module crosstalk_pair_gen
   import xt_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter bit          BIDIR = 1'b1,
   localparam int unsigned DIRS  = BIDIR ? 2 : 1,
   localparam int unsigned VW    = $clog2(WIDTH),
   localparam int unsigned TW    = $clog2(NUM_FAULTS * WIDTH * DIRS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ready,
   output logic             valid,
   output logic [WIDTH-1:0] vec,
   output logic             second,
   output logic [TW-1:0]    test_idx,
   output logic [1:0]       fault,
   output logic [VW-1:0]    victim,
   output logic             dir,
   output logic             done
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("crosstalk_pair_gen: WIDTH must be at least 2");
      end
   endgenerate

   fault_e fault_q;

   xt_seq #(.WIDTH(WIDTH), .BIDIR(BIDIR)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
      .busy(valid), .second(second), .dir(dir), .fault(fault_q),
      .victim(victim), .test_idx(test_idx), .done(done)
   );

   xt_pattern #(.WIDTH(WIDTH)) u_pat (
      .victim(victim), .fault(fault_q), .second(second), .vec(vec)
   );

   assign fault = fault_q;

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(vec) && $stable(test_idx)
                             && $stable(second) && $stable(dir)));
   assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && start) |=> $stable(victim) && $stable(fault));
   assert_test_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && second) |=> (!valid || test_idx == $past(test_idx) + 1'b1));
   assert_second_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && second && fault_q == FT_GLITCH_POS)
         |-> ($countones(vec) == WIDTH - 1 && !vec[victim]));
   assert_second_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && second && fault_q == FT_GLITCH_NEG)
         |-> ($onehot0(vec) && vec[victim]));
endmodule

// File: tb/tb_crosstalk_pair_gen.sv
module tb_crosstalk_pair_gen;
   localparam int W      = 8;
   localparam int TESTS  = 4 * W * 2;
   localparam int BEATS  = 2 * TESTS;
   localparam int WU     = 12;
   localparam int BEATSU = 2 * 4 * WU;

   // spot table: {beat index, expected word}
   localparam logic [15:0] SPOT [8] = '{
      {8'd0,   8'b00000000}, {8'd1,   8'b11111110},
      {8'd4,   8'b11111111}, {8'd5,   8'b00000001},
      {8'd120, 8'b01111111}, {8'd121, 8'b10000000},
      {8'd60,  8'b00001000}, {8'd61,  8'b11110111}
   };

   logic clk = 0;
   logic rst_n = 0;
   logic start = 0, ready = 0;
   logic valid, second, dir, done;
   logic [W-1:0] vec;
   logic [5:0] test_idx;
   logic [1:0] fault;
   logic [2:0] victim;

   logic start_u = 0;
   logic valid_u, second_u, dir_u, done_u;
   logic [WU-1:0] vec_u;
   logic [5:0] tidx_u;
   logic [1:0] fault_u;
   logic [3:0] victim_u;

   int checks = 0, fails = 0;
   logic [W-1:0] cap [BEATS];

   always #2.5 clk = ~clk;

   crosstalk_pair_gen #(.WIDTH(W), .BIDIR(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .valid(valid),
      .vec(vec), .second(second), .test_idx(test_idx), .fault(fault),
      .victim(victim), .dir(dir), .done(done));

   crosstalk_pair_gen #(.WIDTH(WU), .BIDIR(1'b0)) dut_u (
      .clk(clk), .rst_n(rst_n), .start(start_u), .ready(1'b1), .valid(valid_u),
      .vec(vec_u), .second(second_u), .test_idx(tidx_u), .fault(fault_u),
      .victim(victim_u), .dir(dir_u), .done(done_u));

   function automatic logic [W-1:0] model_vec(int v, int f, int ph);
      logic [W-1:0] m;
      m = '0;
      m[v] = 1'b1;
      case (f)
         0: return ph ? ~m : '0;
         1: return ph ? m : '1;
         2: return ph ? m : ~m;
         default: return ph ? ~m : m;
      endcase
   endfunction

   function automatic string tag_of(int f);
      case (f)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
   end

   initial begin
      int k;
      bit expect_done;
      bit finished;
      int cnt_u;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!valid && !done, "R1", "valid/done in reset", {valid, done}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      check(!valid && !done, "R1", "idle without start", {valid, done}, 0);

      // main run with periodic back-pressure
      start = 1;
      @(negedge clk);
      start = 0;
      // R2: first word state
      check(valid && vec == 0 && !second && !dir && test_idx == 0 && fault == 0
            && victim == 0, "R2", "first word",
            {valid, vec, second, dir, test_idx}, {1'b1, 8'h00, 1'b0, 1'b0, 6'd0});
      k = 0;
      expect_done = 0;
      finished = 0;
      for (int cyc = 0; cyc < 2000 && !finished; cyc++) begin
         if (cyc > 0) @(negedge clk);
         ready = (cyc % 5) != 3;
         start = (cyc == 41);   // R10: stray start mid-run
         if (expect_done) begin
            check(done && !valid, "R9", "done after last word", {done, valid}, 2'b10);
            check(k == BEATS, "R9", "beats in run", k, BEATS);
            finished = 1;
         end else if (valid) begin
            int t, d, f, v, ph;
            logic [W-1:0] ev;
            t = k / 2; ph = k % 2; d = t % 2; f = (t / 2) % 4; v = t / 8;
            ev = model_vec(v, f, ph);
            check(vec == ev, tag_of(f), "word", vec, ev);
            check(second == ph && dir == d && fault == f && victim == v && test_idx == t,
                  "R7 R8 R10", "order fields",
                  {second, dir, fault, victim, test_idx}, {ph[0], d[0], f[1:0], v[2:0], t[5:0]});
            if (ready) begin
               cap[k] = vec;
               k++;
               if (k == BEATS) expect_done = 1;
            end
         end else begin
            check(0, "R9", "valid dropped early", k, BEATS);
            finished = 1;
         end
      end
      start = 0;
      @(negedge clk);
      check(!done && !valid, "R9", "done lasts one cycle", {done, valid}, 0);

      // spot table
      foreach (SPOT[i]) begin
         check(cap[SPOT[i][15:8]] == SPOT[i][7:0], "R5 R6", "spot word",
               cap[SPOT[i][15:8]], SPOT[i][7:0]);
      end

      // unidirectional 12-bit instance
      start_u = 1;
      @(negedge clk);
      start_u = 0;
      cnt_u = 0;
      finished = 0;
      for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
         if (cyc > 0) @(negedge clk);
         if (valid_u) begin
            if (dir_u) check(0, "R11", "dir stays 0", dir_u, 0);
            if (cnt_u == 38)
               check(vec_u == 12'b000000010000, "R6", "12-bit fall first", vec_u, 12'h010);
            if (cnt_u == 39)
               check(vec_u == 12'b111111101111, "R6", "12-bit fall second", vec_u, 12'hFEF);
            cnt_u++;
         end else if (done_u) begin
            check(cnt_u == BEATSU, "R11", "beats in unidirectional run", cnt_u, BEATSU);
            finished = 1;
         end
      end
      check(finished, "R11", "unidirectional run ended", finished, 1);
      summary();
   end
endmodule